// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a slave on a two-wire serial bus that lets an external master read and write a bank of 8-bit registers. The clock and data lines are sampled by a faster system clock through synchronisers. Edge detection in that clock domain recognises start, repeated start and stop conditions. A 7-bit device address is compared with one of two fixed values, and a pin chooses which one. The block never drives the clock line. It pulls the data line low only through an open-drain enable.

A write transaction carries a pointer byte and then data bytes. Each data byte is stored at the pointer, and the pointer then steps forward. A read transaction returns the register at the pointer and steps the pointer after every byte. The pointer keeps its value between transactions, so a read is usually preceded by a write that carries only the pointer byte. That write can be its own transaction, or it can be joined to the read by a repeated start. The register bank sits outside the block and is reached through a plain address, write-strobe and read-data port.

Top module: `i2c_reg_slave`

## Requirements
- R1: The slave acknowledges the address byte (pulls SDA low on the 9th clock) when the upper seven bits equal 0x59 with `addr_sel`=0, or 0x0E with `addr_sel`=1. The least significant bit of the address byte selects the direction: 0 is write, 1 is read.
- R2: On an address mismatch the slave leaves SDA released for the rest of the transaction. It acknowledges nothing, raises no write strobe and leaves the pointer unchanged until the next start or stop.
- R3: In a write, the first byte after the address is loaded into the pointer. Each later byte is written to the bank at the pointer with one single-cycle strobe, the pointer then increments by one, and every byte is acknowledged.
- R4: In a read, the slave sends the register at the current pointer, MSB first, and increments the pointer after each byte. It goes on sending while the master acknowledges.
- R5: A master NACK after a read byte ends the read. The slave then keeps SDA released through any further clocks until the next start or stop.
- R6: The pointer keeps its value across stops and is changed only by write pointer bytes and by the per-byte increments. A repeated start switches from write to read without a stop in between.
- R7: The pointer wraps from 0xFF to 0x00 for both writes and reads.
- R8: The slave changes its SDA drive only while SCL is low. It releases SDA on a stop condition.
- R9: After reset `sda_oe` and `reg_wr_en` are 0 and `reg_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| addr_sel | input | 1 | Chooses device address 0x59 (0) or 0x0E (1) |
| sda_oe | output | 1 | When 1, the data line is pulled low |
| reg_addr | output | PTR_W | Register pointer, also the bank address |
| reg_wr_en | output | 1 | One-cycle write strobe to the bank |
| reg_wr_data | output | 8 | Data for the bank write |
| reg_rd_data | input | 8 | Bank contents at `reg_addr` |

## Verification
The bench builds the block with its default parameters: an 8-bit pointer, two-stage synchronisers and the two default device addresses. Because the pointer is 8 bits wide, a 256-entry bank model covers the whole address space, so the wrap from 0xFF to 0x00 can be reached within a short transaction. The bus runs at 32 system clocks per bit. That leaves the synchronised SCL edges well inside each bus phase, so a bench monitor can check against the raw clock line that SDA changes only while SCL is low. The `addr_sel` pin is driven both ways, so each fixed address is shown to be acknowledged in one setting and ignored in the other.

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0] DEV_ADDR_0 = 7'h59,
  parameter logic [6:0] DEV_ADDR_1 = 7'h0E,
  parameter int         PTR_W      = 8,
  parameter int         SYNC_N     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             addr_sel,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_addr,
  output logic             reg_wr_en,
  output logic [7:0]       reg_wr_data,
  input  logic [7:0]       reg_rd_data
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WBYTE, S_WACK, S_RBYTE, S_RACK, S_IGN
  } st_t;

  logic [SYNC_N-1:0] scl_sr, sda_sr;
  logic              scl_s, sda_s, scl_d, sda_d;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic [6:0]        my_addr;

  st_t               st;
  logic [3:0]        bit_cnt;
  logic [7:0]        rx_sh, tx_sh;
  logic              is_read, need_ptr, master_nack;
  logic [PTR_W-1:0]  ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_N-2:0], scl_in};
      sda_sr <= {sda_sr[SYNC_N-2:0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s     = scl_sr[SYNC_N-1];
  assign sda_s     = sda_sr[SYNC_N-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign my_addr   = addr_sel ? DEV_ADDR_1 : DEV_ADDR_0;

  assign reg_addr  = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      bit_cnt     <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      is_read     <= 1'b0;
      need_ptr    <= 1'b0;
      master_nack <= 1'b0;
      ptr         <= '0;
      sda_oe      <= 1'b0;
      reg_wr_en   <= 1'b0;
      reg_wr_data <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      if (reg_wr_en) ptr <= ptr + 1'b1;

      if (stop_det) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        st      <= S_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        case (st)
          S_ADDR: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (rx_sh[7:1] == my_addr) begin
                st       <= S_AACK;
                sda_oe   <= 1'b1;
                is_read  <= rx_sh[0];
                need_ptr <= 1'b1;
              end else begin
                st <= S_IGN;
              end
            end
          end

          S_AACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (is_read) begin
                tx_sh  <= {reg_rd_data[6:0], 1'b0};
                sda_oe <= ~reg_rd_data[7];
                st     <= S_RBYTE;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_WBYTE;
              end
            end
          end

          S_WBYTE: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              sda_oe <= 1'b1;
              st     <= S_WACK;
              if (need_ptr) begin
                ptr      <= PTR_W'(rx_sh);
                need_ptr <= 1'b0;
              end else begin
                reg_wr_en   <= 1'b1;
                reg_wr_data <= rx_sh;
              end
            end
          end

          S_WACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              st      <= S_WBYTE;
            end
          end

          S_RBYTE: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe <= 1'b0;
                ptr    <= ptr + 1'b1;
                st     <= S_RACK;
              end else begin
                sda_oe <= ~tx_sh[7];
                tx_sh  <= {tx_sh[6:0], 1'b0};
              end
            end
          end

          S_RACK: begin
            if (scl_rise) begin
              master_nack <= sda_s;
            end else if (scl_fall) begin
              bit_cnt <= '0;
              if (master_nack) begin
                st <= S_IGN;
              end else begin
                tx_sh  <= {reg_rd_data[6:0], 1'b0};
                sda_oe <= ~reg_rd_data[7];
                st     <= S_RBYTE;
              end
            end
          end

          default: ;
        endcase
      end
    end
  end

endmodule

module i2c_reg_slave_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             stop_det,
  input logic             sda_oe,
  input logic             reg_wr_en,
  input logic [PTR_W-1:0] reg_addr,
  input logic             ignoring
);

  assert_sda_moves_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  assert_stop_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> (!sda_oe && !reg_wr_en));

  assert_write_steps_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> (reg_addr == PTR_W'($past(reg_addr) + 1'b1)));

  assert_write_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.PTR_W(PTR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .stop_det (stop_det),
  .sda_oe   (sda_oe),
  .reg_wr_en(reg_wr_en),
  .reg_addr (reg_addr),
  .ignoring (st == S_IGN)
);

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb_top;
  localparam int Q = 8;
  localparam logic [6:0] DEV0 = 7'h59;
  localparam logic [6:0] DEV1 = 7'h0E;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, addr_sel = 1'b0;
  logic       sda_oe, reg_wr_en;
  logic [7:0] reg_addr, reg_wr_data, reg_rd_data;
  wire        sda_line = m_sda & ~sda_oe;

  logic [7:0] bank [256];
  assign reg_rd_data = bank[reg_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) bank[i] <= 8'(i) ^ 8'hA5;
    end else if (reg_wr_en) begin
      bank[reg_addr] <= reg_wr_data;
    end
  end

  i2c_reg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .reg_addr(reg_addr),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data)
  );

  int n_chk = 0, n_bad = 0, viol = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ptr = 8'h00;
  logic [7:0] exp_q[$], act_q[$];
  string      tag_q[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial forever begin
    wait (act_q.size() > 0);
    check(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front(), "read byte");
  end

  logic last_oe = 1'b0;
  always @(posedge clk) begin
    #1;
    if (rst_n && sda_oe !== last_oe && m_scl) viol++;
    last_oe = sda_oe;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_bit(logic b);
    m_sda = b;    tick(Q);
    m_scl = 1'b1; tick(2*Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(ack);
  endtask

  task automatic addr_phase(logic [6:0] dev, logic rw, logic expect_ack, string req);
    logic a;
    send_byte({dev, rw}, a);
    check(req, a, expect_ack ? 1'b0 : 1'b1, "address ack");
  endtask

  task automatic wr_ptr(logic [7:0] p);
    logic a;
    send_byte(p, a);
    check("R3", a, 1'b0, "pointer byte ack");
    exp_ptr = p;
  endtask

  task automatic wr_data(logic [7:0] v, string req);
    logic a;
    send_byte(v, a);
    check(req, a, 1'b0, "data byte ack");
    exp_mem[exp_ptr] = v;
    exp_ptr = exp_ptr + 8'd1;
  endtask

  task automatic rd_data(logic last, string req);
    logic [7:0] v;
    logic b;
    exp_q.push_back(exp_mem[exp_ptr]);
    tag_q.push_back(req);
    exp_ptr = exp_ptr + 8'd1;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    act_q.push_back(v);
    send_bit(last);
  endtask

  initial begin
    logic b;
    logic [7:0] saved_ptr;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i) ^ 8'hA5;
    tick(5);
    check("R9", sda_oe, 1'b0, "reset sda_oe");
    check("R9", reg_wr_en, 1'b0, "reset write strobe");
    check("R9", reg_addr, 8'h00, "reset pointer");
    rst_n = 1'b1;
    tick(5);

    bus_start();
    addr_phase(DEV0, 1'b0, 1'b1, "R1");
    wr_ptr(8'h10);
    wr_data(8'h11, "R3");
    wr_data(8'h22, "R3");
    wr_data(8'h33, "R3");
    bus_stop();
    tick(4);
    check("R3", reg_addr, 8'h13, "pointer after writes");
    check("R8", sda_oe, 1'b0, "released after stop");
    for (int i = 0; i < 3; i++) check("R3", bank[8'h10 + i], exp_mem[8'h10 + i], "bank after write");

    bus_start();
    addr_phase(DEV0, 1'b0, 1'b1, "R6");
    wr_ptr(8'h10);
    bus_start();
    addr_phase(DEV0, 1'b1, 1'b1, "R6");
    rd_data(1'b0, "R4");
    rd_data(1'b0, "R4");
    rd_data(1'b1, "R4");
    bus_stop();
    tick(4);
    check("R4", reg_addr, 8'h13, "pointer after reads");

    bus_start();
    addr_phase(DEV0, 1'b1, 1'b1, "R6");
    rd_data(1'b0, "R6");
    rd_data(1'b1, "R5");
    for (int i = 0; i < 9; i++) begin
      recv_bit(b);
      check("R5", b, 1'b1, "line released after NACK");
    end
    bus_stop();
    tick(4);
    check("R6", reg_addr, 8'h15, "pointer persisted and stepped");

    saved_ptr = reg_addr;
    bus_start();
    addr_phase(DEV1, 1'b0, 1'b0, "R2");
    send_byte(8'h00, b);
    check("R2", b, 1'b1, "no ack after mismatch");
    send_byte(8'h77, b);
    check("R2", b, 1'b1, "no ack after mismatch");
    bus_stop();
    tick(4);
    check("R2", reg_addr, saved_ptr, "pointer untouched");
    check("R2", bank[8'h00], exp_mem[8'h00], "bank[0] untouched");
    check("R2", bank[8'h77], exp_mem[8'h77], "bank[0x77] untouched");

    addr_sel = 1'b1;
    tick(4);
    bus_start();
    addr_phase(DEV1, 1'b0, 1'b1, "R1");
    wr_ptr(8'hFE);
    wr_data(8'hAA, "R7");
    wr_data(8'hBB, "R7");
    wr_data(8'hCC, "R7");
    bus_stop();
    tick(4);
    check("R7", reg_addr, 8'h01, "pointer wrapped on write");
    check("R7", bank[8'h00], 8'hCC, "write after wrap");

    bus_start();
    addr_phase(DEV0, 1'b0, 1'b0, "R1");
    bus_stop();
    tick(4);

    bus_start();
    addr_phase(DEV1, 1'b0, 1'b1, "R1");
    wr_ptr(8'hFF);
    bus_start();
    addr_phase(DEV1, 1'b1, 1'b1, "R6");
    rd_data(1'b0, "R7");
    rd_data(1'b1, "R7");
    bus_stop();
    tick(4);
    check("R7", reg_addr, 8'h01, "pointer wrapped on read");

    wait (act_q.size() == 0);
    tick(2);
    check("R8", viol, 0, "SDA changes while SCL high");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule